// File: doc/BRIEF.md
# Calendar Alarm Matcher with Per-Field Enables

This block watches a running calendar and raises an alarm interrupt when the time reaches a programmed value. Software programs six alarm values in BCD: seconds, minutes, hours, day of month, month and a three-digit year. It also sets a control word. The control word has one enable bit per field and a global enable. The calendar itself is kept elsewhere. It presents its current BCD fields to this block together with a one-cycle strobe in the cycle after each one-second update.

The enabled comparisons are ORed together. A match on any single enabled field therefore fires the alarm. A field whose enable is clear takes no part in the comparison. The result is held in a sticky pending bit, and that bit drives the interrupt output. Software acknowledges the interrupt by writing 1 to that bit.

Writes go through a simple strobe, address and data port. Reads return the addressed register one clock after the address is presented.

Top module: `cal_alarm_match`

## Requirements
- R1: After a synchronous reset, the control word, every alarm value and the pending bit are 0, and `alarm_irq` is low.
- R2: In the control word (address 0), bits 0 to 5 enable the comparison of seconds, minutes, hours, day, month and year, in that order. Bit 6 is the global enable. While bit 6 is 0, no strobe can set the pending bit.
- R3: On a strobe with the global enable set, the alarm fires when at least one enabled field equals its alarm value. Fields whose enable bit is 0 are ignored, even when they match.
- R4: Writes to the alarm values keep only the low bits of the data. Seconds (address 2) and minutes (address 3) keep 7 bits. Hours (address 4) and day (address 5) keep 6 bits. Month (address 6) keeps 5 bits and year (address 7) keeps 12 bits. The control word keeps 7 bits. Reads return the masked value.
- R5: The year is compared as a 12-bit three-digit BCD value, so the hundreds digit in bits 11:8 takes part in the match.
- R6: Comparison happens only in a cycle where `tick_1s` is high. A matching time without a strobe never sets the pending bit.
- R7: A match sets the pending bit, which reads as bit 1 of address 1. `alarm_irq` goes high on the clock edge that samples the strobe. The bit stays set through later strobes, whether or not they match.
- R8: A write to address 1 with data bit 1 set clears the pending bit and lowers `alarm_irq`. A write with data bit 1 clear has no effect.
- R9: When a clear write and a firing strobe fall in the same cycle, the pending bit is left set.
- R10: `rd_data` is registered. It shows the register addressed by `rd_addr` one clock after that address is applied. Unused high bits read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 16 | Registered read data |
| tick_1s | input | 1 | One-cycle strobe after each second update |
| cur_sec | input | 8 | Current seconds, BCD |
| cur_min | input | 8 | Current minutes, BCD |
| cur_hour | input | 8 | Current hours, BCD |
| cur_day | input | 8 | Current day of month, BCD |
| cur_mon | input | 8 | Current month, BCD |
| cur_year | input | 12 | Current year, three BCD digits |
| alarm_irq | output | 1 | Alarm interrupt, level, mirrors the pending bit |

## Verification
The assertions check on every cycle how the pending bit moves:
- it rises only after a strobe with the global enable set;
- it holds unless a clear is written;
- a clear empties it;
- a firing strobe beats a clear in the same cycle.

Only the bench scenarios can show that the per-field enables select the right comparisons and that the OR combination works. The same holds for the masking applied to written values and for the role of the hundreds digit of the year. The bench shows these by programming fixed alarm values and walking a table of control words and calendar values.

// File: rtl/cam_pkg.sv
package cam_pkg;
  localparam int ADDR_W  = 3;
  localparam int NFIELD  = 6;
  localparam int CTL_W   = NFIELD + 1;
  localparam int GEN_BIT = NFIELD;
  localparam int YEAR_W  = 12;
  localparam int PEND_BIT = 1;

  localparam logic [ADDR_W-1:0] ADR_CTL    = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_PEND   = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_FIELD0 = 3'd2;

  // kept bit count of each alarm value: sec, min, hour, day, month, year
  function automatic int field_width(input int idx);
    case (idx)
      0, 1:    return 7;
      2, 3:    return 6;
      4:       return 5;
      default: return YEAR_W;
    endcase
  endfunction
endpackage

// File: rtl/cam_regs.sv
module cam_regs
  import cam_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           wr_en,
  input  logic [ADDR_W-1:0]              wr_addr,
  input  logic [DATA_W-1:0]              wr_data,
  input  logic [ADDR_W-1:0]              rd_addr,
  input  logic                           pend_i,
  output logic [CTL_W-1:0]               ctrl_o,
  output logic [NFIELD-1:0][YEAR_W-1:0]  alm_o,
  output logic [DATA_W-1:0]              rd_data
);
  logic [CTL_W-1:0]  ctrl_q;
  logic [YEAR_W-1:0] alm_q [NFIELD];
  logic [DATA_W-1:0] rd_n;
  logic              unused_hi;

  assign unused_hi = ^wr_data[DATA_W-1:YEAR_W];

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= '0;
    else if (wr_en && wr_addr == ADR_CTL) ctrl_q <= wr_data[CTL_W-1:0];
  end

  for (genvar i = 0; i < NFIELD; i++) begin : g_field
    localparam logic [YEAR_W-1:0] MASK = YEAR_W'((1 << field_width(i)) - 1);
    localparam logic [ADDR_W-1:0] ADR  = ADR_FIELD0 + ADDR_W'(i);
    always_ff @(posedge clk) begin
      if (rst) alm_q[i] <= '0;
      else if (wr_en && wr_addr == ADR) alm_q[i] <= wr_data[YEAR_W-1:0] & MASK;
    end
    assign alm_o[i] = alm_q[i];

    // R4: the bits above the kept width stay zero after any write
    if (field_width(i) < YEAR_W) begin : g_chk
      a_r4_mask_kept: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == ADR) |=> (alm_q[i] >> field_width(i)) == '0);
    end
  end

  always_comb begin
    rd_n = '0;
    if (rd_addr == ADR_CTL)  rd_n = DATA_W'(ctrl_q);
    if (rd_addr == ADR_PEND) rd_n[PEND_BIT] = pend_i;
    for (int k = 0; k < NFIELD; k++)
      if (rd_addr == ADR_FIELD0 + ADDR_W'(k)) rd_n = DATA_W'(alm_q[k]);
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_n;
  end

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/cam_match.sv
module cam_match
  import cam_pkg::*;
(
  input  logic                          tick_i,
  input  logic [CTL_W-1:0]              ctrl_i,
  input  logic [NFIELD-1:0][YEAR_W-1:0] alm_i,
  input  logic [NFIELD-1:0][YEAR_W-1:0] cur_i,
  output logic                          fire_o
);
  logic [NFIELD-1:0] hit;

  for (genvar i = 0; i < NFIELD; i++) begin : g_cmp
    assign hit[i] = ctrl_i[i] && (cur_i[i] == alm_i[i]);
  end

  assign fire_o = tick_i && ctrl_i[GEN_BIT] && (|hit);
endmodule

// File: rtl/cam_pend.sv
module cam_pend (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_o
);
  logic pend_q;

  always_ff @(posedge clk) begin
    if (rst)        pend_q <= 1'b0;
    else if (set_i) pend_q <= 1'b1;
    else if (clr_i) pend_q <= 1'b0;
  end

  assign pend_o = pend_q;

  // R6: the bit only rises after a firing strobe
  a_r6_rise_needs_fire: assert property (@(posedge clk) disable iff (rst)
    (!pend_q && !set_i) |=> !pend_q);
  // R7: sticky until cleared
  a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
    (pend_q && !clr_i) |=> pend_q);
  // R8: a clear without a new match empties the bit
  a_r8_clear: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !set_i) |=> !pend_q);
  // R9: a firing strobe wins over a clear
  a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
    set_i |=> pend_q);
endmodule

// File: rtl/cal_alarm_match.sv
module cal_alarm_match
  import cam_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [2:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              tick_1s,
  input  logic [7:0]        cur_sec,
  input  logic [7:0]        cur_min,
  input  logic [7:0]        cur_hour,
  input  logic [7:0]        cur_day,
  input  logic [7:0]        cur_mon,
  input  logic [11:0]       cur_year,
  output logic              alarm_irq
);
  logic [CTL_W-1:0]              ctrl;
  logic [NFIELD-1:0][YEAR_W-1:0] alm;
  logic [NFIELD-1:0][YEAR_W-1:0] cur;
  logic                          fire;
  logic                          clr;
  logic                          pend;

  assign cur[0] = YEAR_W'(cur_sec);
  assign cur[1] = YEAR_W'(cur_min);
  assign cur[2] = YEAR_W'(cur_hour);
  assign cur[3] = YEAR_W'(cur_day);
  assign cur[4] = YEAR_W'(cur_mon);
  assign cur[5] = cur_year;

  assign clr = wr_en && (wr_addr == ADR_PEND) && wr_data[PEND_BIT];

  cam_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .pend_i(pend), .ctrl_o(ctrl), .alm_o(alm), .rd_data(rd_data)
  );

  cam_match u_match (
    .tick_i(tick_1s), .ctrl_i(ctrl), .alm_i(alm), .cur_i(cur), .fire_o(fire)
  );

  cam_pend u_pend (
    .clk(clk), .rst(rst), .set_i(fire), .clr_i(clr), .pend_o(pend)
  );

  assign alarm_irq = pend;

  // R2: with the global enable off, the interrupt cannot rise
  a_r2_global_gate: assert property (@(posedge clk) disable iff (rst)
    (!ctrl[GEN_BIT] && !alarm_irq) |=> !alarm_irq);
  // R6: without a strobe, the interrupt cannot rise
  a_r6_strobe_gate: assert property (@(posedge clk) disable iff (rst)
    (!tick_1s && !alarm_irq) |=> !alarm_irq);
endmodule

// File: tb/sim_cal_alarm_match.sv
module sim_cal_alarm_match;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        tick_1s = 1'b0;
  logic [7:0]  cur_sec = '0, cur_min = '0, cur_hour = '0, cur_day = 8'h01, cur_mon = 8'h01;
  logic [11:0] cur_year = '0;
  logic        alarm_irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  cal_alarm_match u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .tick_1s(tick_1s),
    .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour), .cur_day(cur_day),
    .cur_mon(cur_mon), .cur_year(cur_year), .alarm_irq(alarm_irq)
  );

  // {expect, ctrl[6:0], sec, min, hour, day, mon, year[11:0]}
  // alarm values programmed: sec 30, min 45, hour 12, day 15, mon 06, year 123
  localparam int NV = 10;
  localparam logic [59:0] VEC [NV] = '{
    {1'b1, 7'h41, 8'h30, 8'h00, 8'h00, 8'h01, 8'h01, 12'h000}, // R2/R3 sec match
    {1'b0, 7'h01, 8'h30, 8'h00, 8'h00, 8'h01, 8'h01, 12'h000}, // R2 global off
    {1'b0, 7'h42, 8'h30, 8'h00, 8'h00, 8'h01, 8'h01, 12'h000}, // R3 sec not enabled
    {1'b1, 7'h42, 8'h00, 8'h45, 8'h00, 8'h01, 8'h01, 12'h000}, // R3 min match
    {1'b1, 7'h7F, 8'h00, 8'h00, 8'h00, 8'h01, 8'h06, 12'h000}, // R3 OR: month only
    {1'b0, 7'h6F, 8'h00, 8'h00, 8'h00, 8'h01, 8'h06, 12'h000}, // R3 month disabled
    {1'b1, 7'h60, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 12'h123}, // R5 year match
    {1'b0, 7'h60, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 12'h023}, // R5 hundreds differ
    {1'b1, 7'h44, 8'h00, 8'h00, 8'h12, 8'h01, 8'h01, 12'h000}, // R3 hour match
    {1'b1, 7'h48, 8'h00, 8'h00, 8'h00, 8'h15, 8'h01, 12'h000}  // R3 day match
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic pulse();
    @(negedge clk);
    tick_1s = 1'b1;
    @(negedge clk);
    tick_1s = 1'b0;
  endtask

  task automatic set_time(input logic [59:0] v);
    cur_sec = v[51:44]; cur_min = v[43:36]; cur_hour = v[35:28];
    cur_day = v[27:20]; cur_mon = v[19:12]; cur_year = v[11:0];
  endtask

  initial begin
    logic [15:0] r;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 irq", {15'd0, alarm_irq}, 16'h0);
    rd(3'd0, r); chk("R1 ctrl", r, 16'h0);
    rd(3'd2, r); chk("R1 alarm sec", r, 16'h0);
    rd(3'd1, r); chk("R1 pending", r, 16'h0);

    wr(3'd2, 16'h0030); wr(3'd3, 16'h0045); wr(3'd4, 16'h0012);
    wr(3'd5, 16'h0015); wr(3'd6, 16'h0006); wr(3'd7, 16'h0123);
    rd(3'd7, r); chk("R10 year readback", r, 16'h0123);

    for (int i = 0; i < NV; i++) begin
      wr(3'd0, {9'd0, VEC[i][58:52]});
      wr(3'd1, 16'h0002);
      set_time(VEC[i]);
      pulse();
      chk($sformatf("R3 vector %0d", i), {15'd0, alarm_irq}, {15'd0, VEC[i][59]});
    end

    // R6: matching time held without strobe
    wr(3'd0, 16'h0041); wr(3'd1, 16'h0002);
    cur_sec = 8'h30;
    repeat (4) @(negedge clk);
    chk("R6 no strobe", {15'd0, alarm_irq}, 16'h0);

    // R7: fire, then mismatching strobe keeps it
    pulse();
    chk("R7 set", {15'd0, alarm_irq}, 16'h1);
    cur_sec = 8'h00;
    pulse();
    chk("R7 sticky", {15'd0, alarm_irq}, 16'h1);
    rd(3'd1, r); chk("R7 pending bit1", r, 16'h0002);

    // R8: write 0 has no effect, write 1 clears
    wr(3'd1, 16'hFFFD);
    chk("R8 write0 ignored", {15'd0, alarm_irq}, 16'h1);
    wr(3'd1, 16'h0002);
    chk("R8 clear", {15'd0, alarm_irq}, 16'h0);

    // R9: clear and match in one cycle
    cur_sec = 8'h30;
    @(negedge clk);
    tick_1s = 1'b1; wr_en = 1'b1; wr_addr = 3'd1; wr_data = 16'h0002;
    @(negedge clk);
    tick_1s = 1'b0; wr_en = 1'b0;
    chk("R9 set wins", {15'd0, alarm_irq}, 16'h1);

    // R4 masks
    wr(3'd2, 16'hFFFF); rd(3'd2, r); chk("R4 sec mask", r, 16'h007F);
    wr(3'd3, 16'hFFFF); rd(3'd3, r); chk("R4 min mask", r, 16'h007F);
    wr(3'd4, 16'hFFFF); rd(3'd4, r); chk("R4 hour mask", r, 16'h003F);
    wr(3'd5, 16'hFFFF); rd(3'd5, r); chk("R4 day mask", r, 16'h003F);
    wr(3'd6, 16'hFFFF); rd(3'd6, r); chk("R4 mon mask", r, 16'h001F);
    wr(3'd7, 16'hFFFF); rd(3'd7, r); chk("R4 year mask", r, 16'h0FFF);
    wr(3'd0, 16'hFFFF); rd(3'd0, r); chk("R4 ctrl mask", r, 16'h007F);

    // R1 reset again clears everything
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R1 irq after reset", {15'd0, alarm_irq}, 16'h0);
    rd(3'd0, r); chk("R1 ctrl after reset", r, 16'h0);
    rd(3'd7, r); chk("R1 year after reset", r, 16'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule